// File: doc/BRIEF.md
# Network-to-Memory Message Receiver

This block sits between a tile's network port and its two local memories. Inbound messages arrive one word per cycle and are written straight into instruction memory or data memory. The local core takes no part in the transfer. Every message is framed as a header, then an address, then one or more payload words, then a tail. Bit 0 of the header picks the target memory. The receiver does not record who sent a message, so any tile may write to it.

The block drives a write port for each memory: enable, address and write data. The address word sets the first write location. Each later payload word goes to the next location, and the address wraps at the end of the memory. When a data-memory message completes, the block raises a one-cycle arrival event, which releases a core that is stalled waiting for inbound data. Framing violations are dropped and set a sticky error flag that only reset clears.

Top module: `msgrx_top`

## Requirements
- R1: A message is accepted only in the order header, address, one or more payload words, tail. Word kinds on `msg_kind`: 0 header, 1 address, 2 payload, 3 tail. Header bit 0 selects the target: 1 is instruction memory, 0 is data memory. At most one memory write enable is high in any cycle.
- R2: The address word loads the write pointer from its low bits. Each payload word writes at the pointer and then advances it by one.
- R3: A payload word of a data-memory message gives one cycle of `dmem_we`, with `dmem_wdata` equal to the low 32 bits of the word.
- R4: A payload word of an instruction-memory message gives one cycle of `imem_we`, with `imem_wdata` equal to all 96 bits of the word.
- R5: Write addresses wrap modulo the depth of the target memory: 256 for instruction memory and 512 for data memory.
- R6: A word presented on one rising edge shows its effect on the outputs after the following rising edge, so the latency is two cycles.
- R7: `data_arrived` pulses high for exactly one cycle when the tail of a data-memory message that wrote at least one payload word is accepted. The tail of an instruction-memory message gives no pulse.
- R8: An address, payload or tail word that arrives with no open message is dropped, causes no write, and sets `proto_err`.
- R9: `proto_err` stays set until reset, even while later valid messages are processed.
- R10: A tail that follows the address with no payload word in between ends the message, gives no arrival pulse, and sets `proto_err`.
- R11: While `msg_valid` is low, the block ignores `msg_kind` and `msg_word`.
- R12: After reset, all write enables, `data_arrived` and `proto_err` are low.
- R13: A header that arrives while a message is still open aborts that message, sets `proto_err`, and starts a new message that then completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | An inbound word is present this cycle |
| msg_kind | input | 2 | Word kind: 0 header, 1 address, 2 payload, 3 tail |
| msg_word | input | 96 | Inbound word |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 8 | Instruction memory write address |
| imem_wdata | output | 96 | Instruction memory write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 9 | Data memory write address |
| dmem_wdata | output | 32 | Data memory write data |
| data_arrived | output | 1 | One-cycle event marking a completed data-memory message |
| proto_err | output | 1 | Sticky framing error |

## Verification
The assertions assume that `msg_kind` and `msg_word` are fully known whenever `msg_valid` is high. They also assume that every well-formed message carries an address word between two headers, so two consecutive data-memory writes always belong to the same message and step the address by one. The stimulus drives all inputs at falling edges with defined values. It always places a header and an address between messages, so back-to-back writes from different messages never occur. Malformed framing is applied only in the directed tests, which check the error flag and the write counts at the ports.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;

    typedef enum logic [1:0] {
        W_HEAD = 2'd0,
        W_ADDR = 2'd1,
        W_DATA = 2'd2,
        W_TAIL = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_WANT_ADDR = 2'd1,
        S_BODY      = 2'd2
    } frame_state_e;

endpackage

// File: rtl/msgrx_in_stage.sv
module msgrx_in_stage
    import msgrx_pkg::*;
#(
    parameter int WORD_W = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  word_kind_e        kind_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output word_kind_e        kind_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic              valid;
        word_kind_e        kind;
        logic [WORD_W-1:0] word;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = valid_i;
        if (valid_i) begin
            stage_d.kind = kind_i;
            stage_d.word = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '{valid: 1'b0, kind: W_HEAD, word: '0};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign valid_o = stage_q.valid;
    assign kind_o  = stage_q.kind;
    assign word_o  = stage_q.word;

endmodule

// File: rtl/msgrx_frame_fsm.sv
module msgrx_frame_fsm
    import msgrx_pkg::*;
#(
    parameter int IADDR_W = 8,
    parameter int DADDR_W = 9,
    parameter int PTR_W   = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  word_kind_e       kind_i,
    input  logic [PTR_W-1:0] word_lo_i,
    output logic             wr_imem_o,
    output logic             wr_dmem_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [PTR_W-1:0] IMASK = {PTR_W{1'b1}} >> (PTR_W - IADDR_W);
    localparam logic [PTR_W-1:0] DMASK = {PTR_W{1'b1}} >> (PTR_W - DADDR_W);

    typedef struct packed {
        frame_state_e     st;
        logic             to_imem;
        logic [PTR_W-1:0] ptr;
        logic             have_data;
        logic             err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [PTR_W-1:0] mask;

    always_comb begin
        fsm_d     = fsm_q;
        wr_imem_o = 1'b0;
        wr_dmem_o = 1'b0;
        done_o    = 1'b0;
        wr_ptr_o  = fsm_q.ptr;
        mask      = fsm_q.to_imem ? IMASK : DMASK;
        if (valid_i) begin
            unique case (kind_i)
                W_HEAD: begin
                    if (fsm_q.st != S_IDLE) begin
                        fsm_d.err = 1'b1;
                    end
                    fsm_d.st        = S_WANT_ADDR;
                    fsm_d.to_imem   = word_lo_i[0];
                    fsm_d.have_data = 1'b0;
                end
                W_ADDR: begin
                    if (fsm_q.st == S_WANT_ADDR) begin
                        fsm_d.ptr = word_lo_i & mask;
                        fsm_d.st  = S_BODY;
                    end else begin
                        fsm_d.err = 1'b1;
                    end
                end
                W_DATA: begin
                    if (fsm_q.st == S_BODY) begin
                        wr_imem_o       = fsm_q.to_imem;
                        wr_dmem_o       = !fsm_q.to_imem;
                        fsm_d.ptr       = (fsm_q.ptr + 1'b1) & mask;
                        fsm_d.have_data = 1'b1;
                    end else begin
                        fsm_d.err = 1'b1;
                        fsm_d.st  = S_IDLE;
                    end
                end
                W_TAIL: begin
                    if (fsm_q.st == S_BODY && fsm_q.have_data) begin
                        done_o = !fsm_q.to_imem;
                    end else begin
                        fsm_d.err = 1'b1;
                    end
                    fsm_d.st = S_IDLE;
                end
                default: fsm_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: S_IDLE, to_imem: 1'b0, ptr: '0, have_data: 1'b0, err: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign err_o = fsm_q.err;

    // Words outside an open message never write and always flag an error (R8)
    assert_orphan_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == S_IDLE && valid_i && kind_i != W_HEAD)
            |-> (!wr_imem_o && !wr_dmem_o && !done_o) ##1 err_o);

    // Error flag never clears while out of reset (R9)
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // A tail straight after the address completes nothing (R10)
    assert_empty_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == S_BODY && !fsm_q.have_data && valid_i && kind_i == W_TAIL)
            |-> !done_o);

endmodule

// File: rtl/msgrx_wr_stage.sv
module msgrx_wr_stage #(
    parameter int WORD_W  = 96,
    parameter int DATA_W  = 32,
    parameter int IADDR_W = 8,
    parameter int DADDR_W = 9,
    parameter int PTR_W   = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_imem_i,
    input  logic               wr_dmem_i,
    input  logic [PTR_W-1:0]   ptr_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               done_i,
    output logic               imem_we_o,
    output logic [IADDR_W-1:0] imem_addr_o,
    output logic [WORD_W-1:0]  imem_wdata_o,
    output logic               dmem_we_o,
    output logic [DADDR_W-1:0] dmem_addr_o,
    output logic [DATA_W-1:0]  dmem_wdata_o,
    output logic               arrived_o
);

    typedef struct packed {
        logic               iwe;
        logic [IADDR_W-1:0] iaddr;
        logic [WORD_W-1:0]  idata;
        logic               dwe;
        logic [DADDR_W-1:0] daddr;
        logic [DATA_W-1:0]  ddata;
        logic               arr;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d       = wr_q;
        wr_d.iwe   = wr_imem_i;
        wr_d.dwe   = wr_dmem_i;
        wr_d.arr   = done_i;
        if (wr_imem_i) begin
            wr_d.iaddr = ptr_i[IADDR_W-1:0];
            wr_d.idata = word_i;
        end
        if (wr_dmem_i) begin
            wr_d.daddr = ptr_i[DADDR_W-1:0];
            wr_d.ddata = word_i[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign imem_we_o    = wr_q.iwe;
    assign imem_addr_o  = wr_q.iaddr;
    assign imem_wdata_o = wr_q.idata;
    assign dmem_we_o    = wr_q.dwe;
    assign dmem_addr_o  = wr_q.daddr;
    assign dmem_wdata_o = wr_q.ddata;
    assign arrived_o    = wr_q.arr;

    // Only one memory is written per cycle (R1)
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_we_o && dmem_we_o));

    // Consecutive data writes step the address by one, wrapping (R2, R5)
    assert_daddr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we_o && $past(dmem_we_o)) |-> dmem_addr_o == DADDR_W'($past(dmem_addr_o) + 1'b1));

    assert_iaddr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we_o && $past(imem_we_o)) |-> imem_addr_o == IADDR_W'($past(imem_addr_o) + 1'b1));

    // Arrival event is a single cycle and never coincides with a write (R7)
    assert_arrive_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arrived_o |=> !arrived_o);

    assert_arrive_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arrived_o |-> (!imem_we_o && !dmem_we_o));

endmodule

// File: rtl/msgrx_top.sv
module msgrx_top
    import msgrx_pkg::*;
#(
    parameter int INSTR_W    = 96,
    parameter int DATA_W     = 32,
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 512
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          msg_valid,
    input  logic [1:0]                    msg_kind,
    input  logic [INSTR_W-1:0]            msg_word,
    output logic                          imem_we,
    output logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    output logic [INSTR_W-1:0]            imem_wdata,
    output logic                          dmem_we,
    output logic [$clog2(DMEM_DEPTH)-1:0] dmem_addr,
    output logic [DATA_W-1:0]             dmem_wdata,
    output logic                          data_arrived,
    output logic                          proto_err
);

    localparam int IADDR_W = $clog2(IMEM_DEPTH);
    localparam int DADDR_W = $clog2(DMEM_DEPTH);
    localparam int PTR_W   = (IADDR_W > DADDR_W) ? IADDR_W : DADDR_W;

    logic              st_valid;
    word_kind_e        st_kind;
    logic [INSTR_W-1:0] st_word;
    logic              wr_imem, wr_dmem, done;
    logic [PTR_W-1:0]  wr_ptr;

    msgrx_in_stage #(.WORD_W(INSTR_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (msg_valid),
        .kind_i  (word_kind_e'(msg_kind)),
        .word_i  (msg_word),
        .valid_o (st_valid),
        .kind_o  (st_kind),
        .word_o  (st_word)
    );

    msgrx_frame_fsm #(.IADDR_W(IADDR_W), .DADDR_W(DADDR_W), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (st_valid),
        .kind_i    (st_kind),
        .word_lo_i (st_word[PTR_W-1:0]),
        .wr_imem_o (wr_imem),
        .wr_dmem_o (wr_dmem),
        .wr_ptr_o  (wr_ptr),
        .done_o    (done),
        .err_o     (proto_err)
    );

    msgrx_wr_stage #(
        .WORD_W(INSTR_W), .DATA_W(DATA_W),
        .IADDR_W(IADDR_W), .DADDR_W(DADDR_W), .PTR_W(PTR_W)
    ) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_imem_i    (wr_imem),
        .wr_dmem_i    (wr_dmem),
        .ptr_i        (wr_ptr),
        .word_i       (st_word),
        .done_i       (done),
        .imem_we_o    (imem_we),
        .imem_addr_o  (imem_addr),
        .imem_wdata_o (imem_wdata),
        .dmem_we_o    (dmem_we),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .arrived_o    (data_arrived)
    );

    // Nothing can happen at the outputs while idle input stays low for two cycles (R11, R6)
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && !st_valid) |=> (!imem_we && !dmem_we && !data_arrived));

endmodule

// File: tb/test_msgrx_top.sv
`timescale 1ns/1ps
module test_msgrx_top;

    localparam logic [1:0] K_H = 2'd0, K_A = 2'd1, K_D = 2'd2, K_T = 2'd3;
    localparam logic [1:0] E_NONE = 2'd0, E_I = 2'd1, E_D = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [95:0] word;
        logic [1:0]  exp_we;
        logic [8:0]  exp_addr;
        logic        exp_arr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{K_H, 96'h0,                          E_NONE, 9'd0,   1'b0}, // R1 data msg
        '{K_A, 96'd5,                          E_NONE, 9'd0,   1'b0}, // R2
        '{K_D, 96'hFFFF_0000_0000_0000_0000_00A1, E_D, 9'd5,   1'b0}, // R3 low bits only
        '{K_D, 96'h0000_0000_0000_0000_0000_00A2, E_D, 9'd6,   1'b0}, // R2 step
        '{K_T, 96'h0,                          E_NONE, 9'd0,   1'b1}, // R7 pulse
        '{K_H, 96'h1,                          E_NONE, 9'd0,   1'b0}, // R1 instr msg
        '{K_A, 96'd255,                        E_NONE, 9'd0,   1'b0},
        '{K_D, 96'h1111_2222_3333_4444_5555_6666, E_I, 9'd255, 1'b0}, // R4 full width
        '{K_D, 96'h7777_8888_9999_AAAA_BBBB_CCCC, E_I, 9'd0,   1'b0}, // R5 wrap 256
        '{K_T, 96'h0,                          E_NONE, 9'd0,   1'b0}, // R7 no pulse for instr
        '{K_H, 96'h0,                          E_NONE, 9'd0,   1'b0},
        '{K_A, 96'd511,                        E_NONE, 9'd0,   1'b0},
        '{K_D, 96'h0000_0000_0000_0000_1234_5678, E_D, 9'd511, 1'b0},
        '{K_D, 96'h0000_0000_0000_0000_8765_4321, E_D, 9'd0,   1'b0}, // R5 wrap 512
        '{K_T, 96'h0,                          E_NONE, 9'd0,   1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_kind = 2'd0;
    logic [95:0] msg_word = '0;
    logic        imem_we, dmem_we, data_arrived, proto_err;
    logic [7:0]  imem_addr;
    logic [95:0] imem_wdata;
    logic [8:0]  dmem_addr;
    logic [31:0] dmem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int wr_seen = 0;
    int arr_seen = 0;
    logic [8:0] last_daddr = '0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    msgrx_top i_msgrx_top (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_word(msg_word), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .data_arrived(data_arrived), .proto_err(proto_err)
    );

    always @(negedge clk) begin
        if (imem_we || dmem_we) wr_seen++;
        if (dmem_we) last_daddr = dmem_addr;
        if (data_arrived) arr_seen++;
    end

    task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [95:0] w);
        msg_valid = 1'b1;
        msg_kind  = k;
        msg_word  = w;
        @(negedge clk);
    endtask

    task automatic settle();
        msg_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        msg_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wr_seen = 0;
        arr_seen = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!imem_we && !dmem_we && !data_arrived && !proto_err, "R12 reset outputs",
              {92'd0, imem_we, dmem_we, data_arrived, proto_err}, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: vector i shows at the outputs two cycles later (R6)
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                vec_t e;
                bit ok;
                e = VECS[i-2];
                case (e.exp_we)
                    E_I:     ok = imem_we && !dmem_we && imem_addr == e.exp_addr[7:0] && imem_wdata == e.word;
                    E_D:     ok = dmem_we && !imem_we && dmem_addr == e.exp_addr && dmem_wdata == e.word[31:0];
                    default: ok = !imem_we && !dmem_we;
                endcase
                check(ok, "R2/R3/R4/R5/R6 write", {imem_we, dmem_we, dmem_addr, imem_addr, dmem_wdata[31:0]},
                      {e.exp_we, e.exp_addr, e.exp_addr[7:0], e.word[31:0]});
                check(data_arrived == e.exp_arr, "R7 arrival", {95'd0, data_arrived}, {95'd0, e.exp_arr});
            end
            if (i < NV) begin
                msg_valid = 1'b1;
                msg_kind  = VECS[i].kind;
                msg_word  = VECS[i].word;
            end else begin
                msg_valid = 1'b0;
            end
            @(negedge clk);
        end
        check(!proto_err, "R1 clean framing no error", {95'd0, proto_err}, 96'd0);

        // R11: kind/word ignored while valid low
        wr_seen = 0; arr_seen = 0;
        msg_valid = 1'b0; msg_kind = K_D; msg_word = 96'hDEAD;
        repeat (4) @(negedge clk);
        msg_kind = K_T;
        repeat (3) @(negedge clk);
        check(wr_seen == 0 && arr_seen == 0 && !proto_err, "R11 valid low ignored",
              96'(wr_seen + arr_seen), 96'd0);

        // R10: tail right after address
        put(K_H, 96'h0); put(K_A, 96'd3); put(K_T, 96'h0);
        settle();
        check(arr_seen == 0 && wr_seen == 0, "R10 empty message no pulse", 96'(arr_seen), 96'd0);
        check(proto_err, "R10 empty message error", {95'd0, proto_err}, 96'd1);

        // R9: sticky across a good message
        put(K_H, 96'h0); put(K_A, 96'd0); put(K_D, 96'h1); put(K_T, 96'h0);
        settle();
        check(arr_seen == 1 && wr_seen == 1, "R9 good msg still processed", 96'(arr_seen), 96'd1);
        check(proto_err, "R9 error sticky", {95'd0, proto_err}, 96'd1);

        // R12 reset clears error
        do_reset();
        check(!proto_err, "R12 reset clears error", {95'd0, proto_err}, 96'd0);

        // R8: orphan words
        put(K_D, 96'h55); put(K_A, 96'd7); put(K_T, 96'h0);
        settle();
        check(wr_seen == 0 && arr_seen == 0, "R8 orphan dropped", 96'(wr_seen + arr_seen), 96'd0);
        check(proto_err, "R8 orphan error", {95'd0, proto_err}, 96'd1);

        // R13: header inside an open message
        do_reset();
        put(K_H, 96'h0); put(K_A, 96'd10); put(K_D, 96'h11);
        put(K_H, 96'h0); put(K_A, 96'd20); put(K_D, 96'h22); put(K_T, 96'h0);
        settle();
        check(wr_seen == 2 && arr_seen == 1, "R13 restart completes", 96'(wr_seen), 96'd2);
        check(last_daddr == 9'd20, "R13 new address used", {87'd0, last_daddr}, 96'd20);
        check(proto_err, "R13 abort flagged", {95'd0, proto_err}, 96'd1);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule